// File: doc/BRIEF.md
# Audio Output Mute Controller

This block sits between a receive audio buffer and the output formatters of an audio sink. It decides whether the reconstructed audio stream may be heard. A software mute bit overrides everything. Three hardware conditions can also force silence: the external sample-clock PLL has not locked, the receive FIFO has not yet been filled, or the incoming packet stream carries an ancillary no-data indication. A separate hardware-mute enable bit switches those three conditions off as a group.

Two mute outputs are driven. The status bit follows the combined mute request on the next clock. The mute pin changes only at a frame edge, which is the rising edge of the left/right clock for S/PDIF and PCM, or a data-block boundary pulse for one-bit audio. This means the pin never cuts into a partial frame. The same registered pin decision chooses the word handed to the formatter. S/PDIF gets a zero sample with a corrected parity bit. PCM gets all zeros. One-bit audio gets a programmable byte repeated across the word. PCM samples whose validity flag is set are also silenced.

Top module: `audio_mute_ctrl`

## Requirements
- R1: When the registered software mute bit is 1, `mute_status` is 1 on the next clock, whatever the hardware conditions are.
- R2: With the hardware-mute enable set, any one of `pll_locked`=0, `fifo_ready`=0 or `anc_nodata`=1 makes `mute_status` 1 on the next clock.
- R3: With the hardware-mute enable cleared and software mute cleared, the three hardware conditions have no effect, and `mute_status` is 0 on the next clock.
- R4: After reset the software mute bit and the hardware-mute enable are 1, the fill byte is 0x96, `mute_status` and `mute_pin` are 1, and `sample_out`/`flags_out` are 0.
- R5: `mute_status` is active high and equals, one clock later, the mute request formed from the configuration registers and the hardware inputs.
- R6: `mute_pin` loads the mute request only at a boundary: in S/PDIF and PCM modes, a clock where `lrclk` is 1 and was 0 at the previous clock; in one-bit mode (`fmt`=2), a clock where `blk_bound` is 1. It holds at all other clocks.
- R7: In S/PDIF mode (`fmt`=0), while `mute_pin` is 1, the next `sample_out` is 0. In `flags_out` = {P,C,U,V} (bit 3 to bit 0), C, U and V pass through and P equals C^U^V.
- R8: In PCM mode (`fmt`=1 or 3), while `mute_pin` is 1, the next `sample_out` and `flags_out` are all zeros.
- R9: In PCM mode, an input sample with validity `flags_in[0]`=1 gives all-zero `sample_out` and `flags_out` on the next clock, even when `mute_pin` is 0.
- R10: In one-bit mode, while `mute_pin` is 1, the next `sample_out` is the fill byte repeated in every byte lane and `flags_out` is 0.
- R11: When not muted (and for PCM the validity flag is 0), `sample_out` and `flags_out` equal the previous clock's `sample_in` and `flags_in`.
- R12: A clock with `cfg_we`=1 loads the software mute bit, the hardware-mute enable and the fill byte from `cfg_sw_mute`, `cfg_hw_en` and `cfg_fill`. The new values act from the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_sw_mute | input | 1 | Software mute value to load |
| cfg_hw_en | input | 1 | Hardware-mute enable value to load |
| cfg_fill | input | 8 | One-bit fill byte to load |
| pll_locked | input | 1 | External PLL lock indication |
| fifo_ready | input | 1 | Receive FIFO holds data |
| anc_nodata | input | 1 | Ancillary no-data packet seen |
| fmt | input | 2 | Output format: 0 S/PDIF, 1/3 PCM, 2 one-bit |
| lrclk | input | 1 | Left/right frame clock, sampled on clk |
| blk_bound | input | 1 | One-bit data-block boundary pulse |
| sample_in | input | SAMPLE_W | Incoming audio word |
| flags_in | input | 4 | {P,C,U,V} of the incoming word |
| sample_out | output | SAMPLE_W | Word for the formatter |
| flags_out | output | 4 | {P,C,U,V} for the formatter |
| mute_status | output | 1 | Immediate mute status |
| mute_pin | output | 1 | Frame-aligned mute pin |

## Verification
A wrong request term shows on `mute_status` one clock after the offending input or register changes, so it is caught within one step. A corrupt boundary detector shows as `mute_pin` moving between `lrclk` rises or block pulses, or failing to follow at one, and this appears at the first such edge. A bad replacement selection appears on `sample_out`/`flags_out` one clock after the pin decision in every format. The parity term and the repeated fill byte are checked each time that format is muted.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [1:0] {
    FMT_SPDIF  = 2'd0,
    FMT_PCM    = 2'd1,
    FMT_ONEBIT = 2'd2,
    FMT_PCM_B  = 2'd3
  } amc_fmt_e;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLAG_V = 0;
  localparam int unsigned FLAG_U = 1;
  localparam int unsigned FLAG_C = 2;
  localparam int unsigned FLAG_P = 3;
endpackage

// File: rtl/amc_rst_sync.sv
module amc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/amc_cfg_regs.sv
module amc_cfg_regs #(
  parameter logic [7:0] FILL_RESET = 8'h96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       sw_mute_d,
  input  logic       hw_en_d,
  input  logic [7:0] fill_d,
  output logic       sw_mute_q,
  output logic       hw_en_q,
  output logic [7:0] fill_q
);
  logic       sw_nxt;
  logic       hw_nxt;
  logic [7:0] fill_nxt;

  always_comb begin
    sw_nxt   = sw_mute_q;
    hw_nxt   = hw_en_q;
    fill_nxt = fill_q;
    if (we) begin
      sw_nxt   = sw_mute_d;
      hw_nxt   = hw_en_d;
      fill_nxt = fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_mute_q <= 1'b1;
      hw_en_q   <= 1'b1;
      fill_q    <= FILL_RESET;
    end else begin
      sw_mute_q <= sw_nxt;
      hw_en_q   <= hw_nxt;
      fill_q    <= fill_nxt;
    end
  end
endmodule

// File: rtl/amc_mute_decide.sv
module amc_mute_decide
  import amc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sw_mute,
  input  logic     hw_en,
  input  logic     pll_locked,
  input  logic     fifo_ready,
  input  logic     anc_nodata,
  input  amc_fmt_e fmt,
  input  logic     lrclk,
  input  logic     blk_bound,
  output logic     boundary,
  output logic     mute_status,
  output logic     mute_pin
);
  logic lrclk_q;
  logic hw_cond;
  logic req;
  logic pin_nxt;

  always_comb begin
    hw_cond = !pll_locked || !fifo_ready || anc_nodata;
    req     = sw_mute || (hw_en && hw_cond);
    if (fmt == FMT_ONEBIT) boundary = blk_bound;
    else                   boundary = lrclk && !lrclk_q;
    pin_nxt = boundary ? req : mute_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrclk_q     <= 1'b0;
      mute_status <= 1'b1;
      mute_pin    <= 1'b1;
    end else begin
      lrclk_q     <= lrclk;
      mute_status <= req;
      mute_pin    <= pin_nxt;
    end
  end
endmodule

// File: rtl/amc_data_sel.sv
module amc_data_sel
  import amc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  amc_fmt_e            fmt,
  input  logic                mute,
  input  logic [7:0]          fill,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [FLAG_W-1:0]   flags_in,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic [FLAG_W-1:0]   flags_out
);
  localparam int unsigned LANES = SAMPLE_W / 8;

  logic [SAMPLE_W-1:0] fill_word;
  logic [SAMPLE_W-1:0] sample_nxt;
  logic [FLAG_W-1:0]   flags_nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fill_word[g*8 +: 8] = fill;
  end

  always_comb begin
    sample_nxt = sample_in;
    flags_nxt  = flags_in;
    unique case (fmt)
      FMT_SPDIF: begin
        if (mute) begin
          sample_nxt        = '0;
          flags_nxt         = flags_in;
          flags_nxt[FLAG_P] = flags_in[FLAG_C] ^ flags_in[FLAG_U] ^ flags_in[FLAG_V];
        end
      end
      FMT_ONEBIT: begin
        if (mute) begin
          sample_nxt = fill_word;
          flags_nxt  = '0;
        end
      end
      default: begin
        if (mute || flags_in[FLAG_V]) begin
          sample_nxt = '0;
          flags_nxt  = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out <= '0;
      flags_out  <= '0;
    end else begin
      sample_out <= sample_nxt;
      flags_out  <= flags_nxt;
    end
  end
endmodule

// File: rtl/audio_mute_ctrl.sv
module audio_mute_ctrl
  import amc_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 24,
  parameter logic [7:0]  FILL_RESET = 8'h96
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_sw_mute,
  input  logic                cfg_hw_en,
  input  logic [7:0]          cfg_fill,
  input  logic                pll_locked,
  input  logic                fifo_ready,
  input  logic                anc_nodata,
  input  logic [1:0]          fmt,
  input  logic                lrclk,
  input  logic                blk_bound,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [3:0]          flags_in,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic [3:0]          flags_out,
  output logic                mute_status,
  output logic                mute_pin
);
  logic       rst_s_n;
  logic       sw_q;
  logic       hw_en_q;
  logic [7:0] fill_q;
  logic       boundary;
  amc_fmt_e   fmt_e;

  assign fmt_e = amc_fmt_e'(fmt);

  amc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  amc_cfg_regs #(.FILL_RESET(FILL_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .we(cfg_we),
    .sw_mute_d(cfg_sw_mute), .hw_en_d(cfg_hw_en), .fill_d(cfg_fill),
    .sw_mute_q(sw_q), .hw_en_q(hw_en_q), .fill_q(fill_q)
  );

  amc_mute_decide u_dec (
    .clk(clk), .rst_n(rst_s_n), .sw_mute(sw_q), .hw_en(hw_en_q),
    .pll_locked(pll_locked), .fifo_ready(fifo_ready), .anc_nodata(anc_nodata),
    .fmt(fmt_e), .lrclk(lrclk), .blk_bound(blk_bound),
    .boundary(boundary), .mute_status(mute_status), .mute_pin(mute_pin)
  );

  amc_data_sel #(.SAMPLE_W(SAMPLE_W)) u_sel (
    .clk(clk), .rst_n(rst_s_n), .fmt(fmt_e), .mute(mute_pin), .fill(fill_q),
    .sample_in(sample_in), .flags_in(flags_in),
    .sample_out(sample_out), .flags_out(flags_out)
  );
endmodule

// File: rtl/audio_mute_ctrl_chk.sv
module audio_mute_ctrl_chk #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          fmt,
  input logic                pll_locked,
  input logic                sw_q,
  input logic                hw_en_q,
  input logic [7:0]          fill_q,
  input logic                boundary,
  input logic                mute_status,
  input logic                mute_pin,
  input logic [SAMPLE_W-1:0] sample_out,
  input logic [3:0]          flags_out
);
  p_sw_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |=> mute_status);

  p_pll_mute_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en_q && !pll_locked) |=> mute_status);

  p_hw_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_q && !hw_en_q) |=> !mute_status);

  p_pin_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(mute_pin));

  p_spdif_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd0 && mute_pin) |=> (sample_out == '0 && ^flags_out == 1'b0));

  p_pcm_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fmt == 2'd1 || fmt == 2'd3) && mute_pin) |=> (sample_out == '0 && flags_out == '0));

  p_onebit_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'd2 && mute_pin) |=> (sample_out[7:0] == $past(fill_q) && flags_out == '0));
endmodule

bind audio_mute_ctrl audio_mute_ctrl_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .fmt(fmt), .pll_locked(pll_locked),
  .sw_q(sw_q), .hw_en_q(hw_en_q), .fill_q(fill_q), .boundary(boundary),
  .mute_status(mute_status), .mute_pin(mute_pin),
  .sample_out(sample_out), .flags_out(flags_out)
);

// File: tb/audio_mute_ctrl_test.sv
module audio_mute_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;

  logic          clk;
  logic          rst_n;
  logic          cfg_we, cfg_sw_mute, cfg_hw_en;
  logic [7:0]    cfg_fill;
  logic          pll_locked, fifo_ready, anc_nodata;
  logic [1:0]    fmt;
  logic          lrclk, blk_bound;
  logic [SW-1:0] sample_in;
  logic [3:0]    flags_in;
  logic [SW-1:0] sample_out;
  logic [3:0]    flags_out;
  logic          mute_status, mute_pin;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic          m_sw, m_hw, m_status, m_pin, m_lr_q;
  logic [7:0]    m_fill;
  logic [SW-1:0] m_sample;
  logic [3:0]    m_flags;
  string         m_dtag;

  audio_mute_ctrl #(.SAMPLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sw_mute(cfg_sw_mute),
    .cfg_hw_en(cfg_hw_en), .cfg_fill(cfg_fill), .pll_locked(pll_locked),
    .fifo_ready(fifo_ready), .anc_nodata(anc_nodata), .fmt(fmt), .lrclk(lrclk),
    .blk_bound(blk_bound), .sample_in(sample_in), .flags_in(flags_in),
    .sample_out(sample_out), .flags_out(flags_out),
    .mute_status(mute_status), .mute_pin(mute_pin)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [SW-1:0] fill_rep(input logic [7:0] b);
    logic [SW-1:0] w;
    for (int i = 0; i < SW/8; i++) w[i*8 +: 8] = b;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model update per requirements, then compare all outputs
  task automatic step();
    logic req, bnd;
    @(posedge clk);
    req = m_sw | (m_hw & (!pll_locked | !fifo_ready | anc_nodata));
    bnd = (fmt == 2'd2) ? blk_bound : (lrclk & !m_lr_q);
    if (fmt == 2'd0) begin
      if (m_pin) begin
        m_sample = '0;
        m_flags  = {flags_in[2] ^ flags_in[1] ^ flags_in[0], flags_in[2:0]};
        m_dtag   = "R7";
      end else begin
        m_sample = sample_in; m_flags = flags_in; m_dtag = "R11";
      end
    end else if (fmt == 2'd2) begin
      if (m_pin) begin
        m_sample = fill_rep(m_fill); m_flags = '0; m_dtag = "R10";
      end else begin
        m_sample = sample_in; m_flags = flags_in; m_dtag = "R11";
      end
    end else begin
      if (m_pin) begin
        m_sample = '0; m_flags = '0; m_dtag = "R8";
      end else if (flags_in[0]) begin
        m_sample = '0; m_flags = '0; m_dtag = "R9";
      end else begin
        m_sample = sample_in; m_flags = flags_in; m_dtag = "R11";
      end
    end
    m_status = req;
    if (bnd) m_pin = req;
    m_lr_q = lrclk;
    if (cfg_we) begin
      m_sw = cfg_sw_mute; m_hw = cfg_hw_en; m_fill = cfg_fill;
    end
    #1;
    check("R5 status", {31'd0, mute_status}, {31'd0, m_status});
    check("R6 pin", {31'd0, mute_pin}, {31'd0, m_pin});
    check({m_dtag, " sample"}, {8'd0, sample_out}, {8'd0, m_sample});
    check({m_dtag, " flags"}, {28'd0, flags_out}, {28'd0, m_flags});
    @(negedge clk);
  endtask

  task automatic cfg(input logic sw, input logic hw, input logic [7:0] fb);
    cfg_we = 1'b1; cfg_sw_mute = sw; cfg_hw_en = hw; cfg_fill = fb;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 0; cfg_sw_mute = 0; cfg_hw_en = 0; cfg_fill = 0;
    pll_locked = 0; fifo_ready = 0; anc_nodata = 0; fmt = 2'd1;
    lrclk = 0; blk_bound = 0; sample_in = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    check("R4 status in reset", {31'd0, mute_status}, 32'd1);
    check("R4 pin in reset", {31'd0, mute_pin}, 32'd1);
    check("R4 sample in reset", {8'd0, sample_out}, 32'd0);
    rst_n = 1'b1;
    m_sw = 1; m_hw = 1; m_fill = 8'h96; m_status = 1; m_pin = 1; m_lr_q = 0;
    m_sample = '0; m_flags = '0; m_dtag = "R4";
    repeat (4) step();

    // R4 fill default observed: one-bit mode, still muted
    fmt = 2'd2; step(); step();
    check("R4 default fill byte", {8'd0, sample_out}, {8'd0, fill_rep(8'h96)});

    // R12 new fill byte
    cfg(1'b1, 1'b1, 8'h3C); step();
    check("R12 fill byte loaded", {8'd0, sample_out}, {8'd0, fill_rep(8'h3C)});

    // R1: sw mute wins with every hw condition good
    pll_locked = 1; fifo_ready = 1; anc_nodata = 0; fmt = 2'd1;
    step(); check("R1 sw mute priority", {31'd0, mute_status}, 32'd1);

    // R3: hw disabled, sw off, all conditions bad -> unmuted
    pll_locked = 0; fifo_ready = 0; anc_nodata = 1;
    cfg(1'b0, 1'b0, 8'h3C); step();
    check("R3 hw conditions ignored", {31'd0, mute_status}, 32'd0);
    // R6: pin still 1 until lrclk rises
    check("R6 pin waits for boundary", {31'd0, mute_pin}, 32'd1);
    lrclk = 1; step();
    check("R6 pin released on lrclk rise", {31'd0, mute_pin}, 32'd0);
    // R11 passthrough, R9 validity mute
    sample_in = 24'hABCDEF; flags_in = 4'b0110; step();
    check("R11 passthrough", {8'd0, sample_out}, 32'h00ABCDEF);
    flags_in = 4'b0001; step();
    check("R9 validity zeroes PCM", {8'd0, sample_out}, 32'd0);

    // R2: each hw condition alone
    cfg(1'b0, 1'b1, 8'h3C);
    pll_locked = 1; fifo_ready = 1; anc_nodata = 0; step(); step();
    check("R2 no condition -> unmuted", {31'd0, mute_status}, 32'd0);
    pll_locked = 0; step();
    check("R2 pll unlock mutes", {31'd0, mute_status}, 32'd1);
    pll_locked = 1; fifo_ready = 0; step();
    check("R2 fifo empty mutes", {31'd0, mute_status}, 32'd1);
    fifo_ready = 1; anc_nodata = 1; step();
    check("R2 no-data packet mutes", {31'd0, mute_status}, 32'd1);
    // R7 S/PDIF mute with parity
    fmt = 2'd0; lrclk = 0; step(); lrclk = 1; step();
    check("R6 pin set on lrclk rise", {31'd0, mute_pin}, 32'd1);
    sample_in = 24'h123456; flags_in = 4'b0110; step();
    check("R7 spdif zero sample", {8'd0, sample_out}, 32'd0);
    check("R7 spdif parity", {28'd0, flags_out}, 32'h6);
    // R6 one-bit: lrclk ignored, block pulse used
    fmt = 2'd2; anc_nodata = 0; lrclk = 0; step(); lrclk = 1; step();
    check("R6 lrclk ignored in one-bit", {31'd0, mute_pin}, 32'd1);
    blk_bound = 1; step(); blk_bound = 0;
    check("R6 block boundary releases", {31'd0, mute_pin}, 32'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      cfg_we      = ($urandom_range(0, 19) == 0);
      cfg_sw_mute = ($urandom_range(0, 3) == 0);
      cfg_hw_en   = $urandom_range(0, 1);
      cfg_fill    = 8'($urandom);
      pll_locked  = ($urandom_range(0, 7) != 0);
      fifo_ready  = ($urandom_range(0, 7) != 0);
      anc_nodata  = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 49) == 0) fmt = 2'($urandom);
      if ($urandom_range(0, 2) == 0) lrclk = ~lrclk;
      blk_bound   = ($urandom_range(0, 5) == 0);
      sample_in   = SW'($urandom);
      flags_in    = 4'($urandom);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule